// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block takes one fast clock and derives two slower clocks from it. The first derived clock runs at one half or one quarter of the input rate. The second runs at one quarter, one fifth or one sixth of the input rate. Static select inputs pick the ratios. Both divider chains advance on the same rising edge of the input clock, so whenever the two derived clocks share an edge they switch together.

An active-low run control stops and restarts both chains. It is captured on the falling edge of the input clock, which is the half-cycle in which the input clock is low. A stop or a restart therefore begins on a full rising edge and never on a shortened pulse. While the block is stopped, both outputs hold their level and the counters keep their position. A synchronous active-high reset puts both chains into one fixed phase, so several copies can be lined up. After reset both outputs are low, and they rise together on the first enabled rising edge.

Top module: `dual_ratio_clk_divider`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, both outputs are low after that edge, whatever the other inputs are.
- R2: `sel_a_i` = 0 makes `clk_a_o` a divide-by-2 clock (high 1 input cycle, low 1). `sel_a_i` = 1 makes it a divide-by-4 clock (high 2, low 2).
- R3: `sel_b_i` picks the ratio of `clk_b_o`: 2'b00 divides by 4 (high 2, low 2), 2'b01 divides by 5, 2'b10 divides by 6 (high 3, low 3), and 2'b11 also divides by 6.
- R4: In divide-by-5 mode, `clk_b_o` is high for 2 input cycles and low for 3 in each period of 5.
- R5: On the first enabled rising edge after reset is released, both outputs go from low to high on that same edge.
- R6: `en_n_i` is active low and is sampled on the falling edge of `clk_i`. The value sampled on a falling edge decides whether the dividers advance on the next rising edge.
- R7: While the block is disabled, both outputs keep their level and both counters keep their position. When the block is enabled again, counting continues from that position.
- R8: A change of a select input takes effect when the divider concerned next completes its current period. The period in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset of both divider chains |
| en_n_i | input | 1 | Active-low run control, sampled on the falling edge |
| sel_a_i | input | 1 | Ratio select for output A: 0 gives /2, 1 gives /4 |
| sel_b_i | input | 2 | Ratio select for output B: 00 gives /4, 01 gives /5, 10 and 11 give /6 |
| clk_a_o | output | 1 | Divided clock A |
| clk_b_o | output | 1 | Divided clock B |

## Verification
The hardest case to reach from the ports is a ratio change, or a stop, that lands in the middle of a period. The chain must then finish its current period at the old ratio, or hold a mid-period count, and not restart. The stimulus changes the selects and toggles the run control at cycle offsets that fall inside a period. It also stops the block for several cycles with output B high and with output B low. A cycle-level reference model in the bench predicts both outputs through each of these events.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        B_DIV4  = 2'b00,
        B_DIV5  = 2'b01,
        B_DIV6  = 2'b10,
        B_DIV6X = 2'b11
    } b_sel_e;

    // last: terminal count (period - 1); hi: input cycles the output is high
    typedef struct packed {
        logic [CNT_W-1:0] last;
        logic [CNT_W-1:0] hi;
    } ratio_t;

    function automatic ratio_t ratio_of_a(input logic sel);
        ratio_t r;
        if (sel) begin
            r.last = CNT_W'(3);
            r.hi   = CNT_W'(2);
        end else begin
            r.last = CNT_W'(1);
            r.hi   = CNT_W'(1);
        end
        return r;
    endfunction

    function automatic ratio_t ratio_of_b(input logic [1:0] sel);
        ratio_t r;
        case (b_sel_e'(sel))
            B_DIV4: begin
                r.last = CNT_W'(3);
                r.hi   = CNT_W'(2);
            end
            B_DIV5: begin
                r.last = CNT_W'(4);
                r.hi   = CNT_W'(2);
            end
            default: begin
                r.last = CNT_W'(5);
                r.hi   = CNT_W'(3);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dcd_enable_capture.sv
module dcd_enable_capture (
    input  logic clk_i,
    input  logic en_n_i,
    output logic run_o
);

    // Captured while the input clock is low: the dividers only see
    // a change of run state at the start of a full rising edge.
    always_ff @(negedge clk_i) begin
        run_o <= ~en_n_i;
    end

endmodule

// File: rtl/dcd_ratio_decode.sv
module dcd_ratio_decode #(
    parameter int SEL_W = 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output dcd_pkg::ratio_t  ratio_o
);

    generate
        if (SEL_W == 1) begin : g_short
            always_comb ratio_o = dcd_pkg::ratio_of_a(sel_i[0]);
        end else begin : g_long
            always_comb ratio_o = dcd_pkg::ratio_of_b(sel_i[1:0]);
        end
    endgenerate

endmodule

// File: rtl/dcd_divider_chain.sv
module dcd_divider_chain
    import dcd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   run_i,
    input  ratio_t req_i,
    output logic   clk_o
);

    logic [CNT_W-1:0] cnt_q;
    ratio_t           act_q;
    logic             out_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb cnt_nxt = cnt_q + CNT_W'(1);

    // Reset parks the counter on its terminal count with the output low,
    // so the first enabled edge wraps it and raises the output.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= req_i.last;
            act_q <= req_i;
            out_q <= 1'b0;
        end else if (run_i) begin
            if (cnt_q >= act_q.last) begin
                cnt_q <= '0;
                act_q <= req_i;
                out_q <= 1'b1;
            end else begin
                cnt_q <= cnt_nxt;
                out_q <= (cnt_nxt < act_q.hi);
            end
        end
    end

    assign clk_o = out_q;

endmodule

// File: rtl/dual_ratio_clk_divider.sv
module dual_ratio_clk_divider (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_n_i,
    input  logic       sel_a_i,
    input  logic [1:0] sel_b_i,
    output logic       clk_a_o,
    output logic       clk_b_o
);

    import dcd_pkg::*;

    logic   run_q;
    ratio_t ratio_a;
    ratio_t ratio_b;

    dcd_enable_capture u_en (
        .clk_i  (clk_i),
        .en_n_i (en_n_i),
        .run_o  (run_q)
    );

    dcd_ratio_decode #(.SEL_W(1)) u_dec_a (
        .sel_i   (sel_a_i),
        .ratio_o (ratio_a)
    );

    dcd_ratio_decode #(.SEL_W(2)) u_dec_b (
        .sel_i   (sel_b_i),
        .ratio_o (ratio_b)
    );

    // Both chains share clock, reset and run, so common edges coincide.
    dcd_divider_chain u_chain_a (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (run_q),
        .req_i (ratio_a),
        .clk_o (clk_a_o)
    );

    dcd_divider_chain u_chain_b (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (run_q),
        .req_i (ratio_b),
        .clk_o (clk_b_o)
    );

endmodule

// File: rtl/dcd_chain_checker.sv
module dcd_chain_checker
    import dcd_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             run_i,
    input logic [CNT_W-1:0] cnt_i,
    input ratio_t           act_i,
    input logic             out_i
);

    logic rst_d;
    always_ff @(posedge clk_i) rst_d <= rst_i;

    // R1: a reset edge leaves the output low
    always @(negedge clk_i) begin
        if (rst_d === 1'b1) begin
            a_r1_reset_low: assert (out_i == 1'b0);
        end
    end

    // R2, R3: count never passes the active terminal count
    a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_i <= act_i.last);

    // R7: stopped chain holds output level
    a_r7_hold_output: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> $stable(out_i));

    // R7: stopped chain holds its count
    a_r7_hold_count: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> $stable(cnt_i));

    // R8: the active ratio only changes on a period boundary
    a_r8_ratio_at_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$stable(act_i)) |-> (cnt_i == '0));

endmodule

bind dcd_divider_chain dcd_chain_checker chk_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (run_i),
    .cnt_i (cnt_q),
    .act_i (act_q),
    .out_i (out_q)
);

// File: tb/dual_ratio_clk_divider_tb_top.sv
`timescale 1ns/1ps
module dual_ratio_clk_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b0;
    logic       sel_a = 1'b0;
    logic [1:0] sel_b = 2'b00;
    logic       out_a;
    logic       out_b;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    dual_ratio_clk_divider dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_n_i  (en_n),
        .sel_a_i (sel_a),
        .sel_b_i (sel_b),
        .clk_a_o (out_a),
        .clk_b_o (out_b)
    );

    // ---------------- reference model (from the requirements) -------------
    typedef struct packed { logic a; logic b; } exp_t;
    exp_t exp_q[$];

    int len_a, len_b, ph_a, ph_b;
    logic ma = 0, mb = 0;

    function automatic int period_a(input logic s);
        return s ? 4 : 2;
    endfunction
    function automatic int period_b(input logic [1:0] s);
        return (s == 2'b00) ? 4 : (s == 2'b01) ? 5 : 6;
    endfunction

    // Each output is high for the first floor(period/2) cycles of a period.
    always @(posedge clk) begin
        if (rst) begin
            len_a = period_a(sel_a); ph_a = len_a - 1; ma = 0;
            len_b = period_b(sel_b); ph_b = len_b - 1; mb = 0;
        end else if (!en_n) begin
            if (ph_a == len_a - 1) begin ph_a = 0; len_a = period_a(sel_a); end
            else ph_a = ph_a + 1;
            if (ph_b == len_b - 1) begin ph_b = 0; len_b = period_b(sel_b); end
            else ph_b = ph_b + 1;
            ma = (ph_a < len_a / 2);
            mb = (ph_b < len_b / 2);
        end
        exp_q.push_back('{a: ma, b: mb});
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (out_a !== e.a || out_b !== e.b) begin
                bad++;
                $display("FAIL %s: outputs a,b actual=%b,%b expected=%b,%b at %0t",
                         tag, out_a, out_b, e.a, e.b, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        int highs;
        // R1: reset with run active and then inactive
        tag = "R1";
        step(3);
        en_n = 1'b1;
        step(2);
        #1;
        check("R1", out_a, 1'b0);
        check("R1", out_b, 1'b0);
        en_n = 1'b0;
        step(1);

        // R5: release, both rise on the first enabled edge
        tag = "R5";
        rst = 1'b0;
        #1;
        check("R5", out_a, 1'b0);
        check("R5", out_b, 1'b0);
        @(posedge clk); #1;
        check("R5", out_a, 1'b1);
        check("R5", out_b, 1'b1);

        // R2 and R3: /2 and /4
        tag = "R2/R3 div2+div4";
        step(24);

        // R4: divide by 5 after a fresh reset
        tag = "R4";
        rst = 1'b1; sel_a = 1'b1; sel_b = 2'b01;
        step(2);
        rst = 1'b0;
        step(5);
        highs = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (out_b) highs++;
        end
        check("R4", (highs == 2), 1'b1);
        step(12);

        // R8: select changes land mid-period
        tag = "R8";
        step(2);
        sel_b = 2'b10;
        sel_a = 1'b0;
        step(20);
        tag = "R3 sel 11";
        sel_b = 2'b11;
        step(18);
        tag = "R3 sel 00";
        sel_b = 2'b00;
        step(16);

        // R6 and R7: stop mid-period with B high, then with B low
        tag = "R7 hold";
        sel_b = 2'b01;
        step(11);
        en_n = 1'b1;
        step(7);
        tag = "R6 resume";
        en_n = 1'b0;
        step(3);
        tag = "R7 hold";
        en_n = 1'b1;
        step(5);
        tag = "R6 resume";
        en_n = 1'b0;
        step(4);
        tag = "R6 single cycle stop";
        en_n = 1'b1;
        step(1);
        en_n = 1'b0;
        step(20);

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule